// File: doc/BRIEF.md
# Programmable Period Tick Timer

This block is a periodic interrupt timer that lives wholly on one fast system clock. A slow time base reaches it as a single-cycle enable (`tick_en`) instead of as a second clock, so every register shares one clock and no signal crosses a domain. Software sets the period by pulsing `wr_en` with a value on `wr_data`. A counter steps once on each enabled tick and is compared against that value.

When the count equals the programmed value, the match is captured into a flag register on that tick. The flag then clears the counter on the following tick. Because of this registered path, a programmed value N produces one interrupt every N+2 enabled ticks, with the counter running through 0 to N+1. The flag is the block's interrupt level. A one-cycle pulse marks the tick on which the flag is set.

The flag is held in a two-state machine. In COUNTING, the last captured comparison was false. In MATCHED, it was true. The transition COUNTING→MATCHED is taken on a tick with an equal comparison. The transition MATCHED→COUNTING is taken on the next tick, which also clears the counter. Without a tick, the machine stays in its current state.

Top module: `periodic_tick_timer`

## Requirements
- R1: An active-low synchronous reset clears the counter, the cycle register and the flag to zero. Because a count of 0 then equals a cycle value of 0, the first tick after reset raises the flag.
- R2: The cycle register takes `wr_data` on every clock edge where `wr_en` is 1. When `wr_en` is 0, changes on `wr_data` have no effect on it.
- R3: The counter and the flag change only on edges where `tick_en` is 1. With no tick, both outputs hold their values.
- R4: On a tick, the flag takes the result of comparing the count with the cycle value as they stood before that edge. On a tick where the flag is already set, the counter returns to 0. On any other tick, it adds one.
- R5: With cycle value N held constant, `irq_flag` rises once every N+2 enabled ticks. For example, N=3 gives a period of 5 ticks.
- R6: `irq_pulse` is high for exactly one clock, in the cycle after the tick whose comparison was equal.
- R7: `irq_flag` is a level that stays unchanged between ticks, whatever the gap between them.
- R8: If a cycle value below the current count is written, the counter keeps incrementing and wraps modulo 2^CNT_W before the next match.
- R9: `irq_pulse` is never high unless `tick_en` was high on the preceding edge. Register writes alone never cause a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the cycle register |
| wr_data | input | CNT_W | Cycle value to load |
| tick_en | input | 1 | One-cycle slow time-base enable |
| irq_flag | output | 1 | Captured match flag (interrupt level, high in MATCHED) |
| irq_pulse | output | 1 | One-cycle pulse when the flag is set |

## Verification
Every result is due one clock after the edge that causes it. A tick or write driven before edge k shows on `irq_flag` and `irq_pulse` just after edge k. The counter clears on the edge after the one that set the flag. For each cycle it drives, the driver pushes the outputs expected after the next rising edge, computed from the tick-level rules. The monitor pops one entry shortly after each rising edge and compares it, so each expectation lines up with exactly one edge. Gaps between ticks, back-to-back ticks, writes that are ignored and the wrap-around case all go through this same one-cycle path.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // State of the captured match flag
    typedef enum logic {
        PH_COUNTING = 1'b0,
        PH_MATCHED  = 1'b1
    } match_phase_e;

endpackage

// File: rtl/tt_cycle_reg.sv
module tt_cycle_reg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cyc_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (wr_en) begin
            cyc_q <= wr_data;
        end
    end

    // R2: no write strobe, no change
    assert_cycle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cyc_q));

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            if (clear) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    // R3: the count moves only on a tick
    assert_count_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

endmodule

// File: rtl/tt_match_fsm.sv
module tt_match_fsm
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cyc,
    output logic             flag,
    output logic             pulse,
    output logic             clear
);

    match_phase_e phase_q, phase_d;
    logic         equal;

    assign equal = (cnt == cyc);

    // Next-state selection
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_COUNTING: if (tick_en && equal) phase_d = PH_MATCHED;
            PH_MATCHED:  if (tick_en) phase_d = equal ? PH_MATCHED : PH_COUNTING;
            default:     phase_d = PH_COUNTING;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_COUNTING;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Output register: pulse on the tick whose comparison is equal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= tick_en && equal;
        end
    end

    assign flag  = (phase_q == PH_MATCHED);
    assign clear = (phase_q == PH_MATCHED);

    // R6: the pulse never lasts two cycles
    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R9: a pulse requires a tick on the previous edge
    assert_pulse_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(tick_en));

    // R7: the flag level holds between ticks
    assert_flag_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(flag));

    // R6: a pulse comes with the flag raised
    assert_pulse_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);

endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick_en,
    output logic             irq_flag,
    output logic             irq_pulse
);

    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             clr;

    tt_cycle_reg #(.CNT_W(CNT_W)) u_cycle (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cyc_q   (cyc_q)
    );

    tt_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clear   (clr),
        .cnt_q   (cnt_q)
    );

    tt_match_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt     (cnt_q),
        .cyc     (cyc_q),
        .flag    (irq_flag),
        .pulse   (irq_pulse),
        .clear   (clr)
    );

    // R4: a tick taken while the flag is set returns the count to zero
    assert_clear_after_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && irq_flag) |=> (cnt_q == '0));

    // R5: after a matched tick the flag drops on the next tick
    assert_flag_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && irq_flag) |=> !irq_flag);

endmodule

// File: tb/periodic_tick_timer_test.sv
module periodic_tick_timer_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         tick_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         irq_flag;
    logic         irq_pulse;

    always #5 clk = ~clk;

    periodic_tick_timer #(.CNT_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tick_en   (tick_en),
        .irq_flag  (irq_flag),
        .irq_pulse (irq_pulse)
    );

    typedef struct {
        logic  pulse;
        logic  flag;
        string req;
    } exp_t;

    exp_t  sb_q[$];
    exp_t  got_e;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Tick-level reference state
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_cyc = '0;
    logic         m_flag = 1'b0;

    // Driver: applies one cycle of stimulus and queues the outputs due after the next edge
    task automatic step(input logic rs, input logic we, input logic [W-1:0] wd, input logic te);
        exp_t e;
        logic eq;
        @(negedge clk);
        rst_n = rs; wr_en = we; wr_data = wd; tick_en = te;
        e.pulse = 1'b0;
        if (!rs) begin
            m_cnt = '0; m_cyc = '0; m_flag = 1'b0;
        end else begin
            if (te) begin
                eq = (m_cnt == m_cyc);
                e.pulse = eq;
                m_cnt = m_flag ? '0 : W'(m_cnt + 1);
                m_flag = eq;
            end
            if (we) m_cyc = wd;
        end
        e.flag = m_flag;
        e.req  = cur_req;
        sb_q.push_back(e);
    endtask

    task automatic check(input logic got, input logic expv, input string what, input string req);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, expv, $time);
        end
    endtask

    // Monitor: one expectation per rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                got_e = sb_q.pop_front();
                check(irq_pulse, got_e.pulse, "irq_pulse", got_e.req);
                check(irq_flag,  got_e.flag,  "irq_flag",  got_e.req);
            end
        end
    end

    initial begin
        // R1: reset state, then first tick matches 0 == 0
        cur_req = "R1";
        repeat (3) step(1'b0, 1'b0, '0, 1'b0);
        repeat (2) step(1'b1, 1'b0, '0, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1);
        step(1'b1, 1'b0, '0, 1'b0);
        step(1'b1, 1'b0, '0, 1'b1);

        // R2: load 3, then a changed wr_data without the strobe is ignored
        cur_req = "R2";
        step(1'b1, 1'b1, 8'd3, 1'b0);
        step(1'b1, 1'b0, 8'd9, 1'b0);

        // R5 R6 R7: sparse ticks, period N+2 = 5
        cur_req = "R5 R6 R7";
        for (int i = 0; i < 15; i++) begin
            step(1'b1, 1'b0, 8'd9, 1'b1);
            step(1'b1, 1'b0, 8'd9, 1'b0);
            step(1'b1, 1'b0, 8'd9, 1'b0);
        end

        // R3: no ticks, outputs frozen
        cur_req = "R3";
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, W'(i * 7), 1'b0);

        // R4 R6: back-to-back ticks with N=1, period 3
        cur_req = "R4 R6";
        step(1'b1, 1'b1, 8'd1, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, '0, 1'b1);

        // R8: run count up under a large value, then drop below it
        cur_req = "R8";
        step(1'b1, 1'b1, 8'd200, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, '0, 1'b1);
        step(1'b1, 1'b1, 8'd2, 1'b0);
        for (int i = 0; i < 270; i++) step(1'b1, 1'b0, '0, 1'b1);

        // R9 R2: writes alone never pulse
        cur_req = "R9 R2";
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, W'(i), 1'b0);

        // R1: reset mid-run, then a tick matches zero again
        cur_req = "R1";
        step(1'b1, 1'b0, '0, 1'b1);
        repeat (2) step(1'b0, 1'b0, '0, 1'b1);
        step(1'b1, 1'b0, '0, 1'b1);
        step(1'b1, 1'b0, '0, 1'b0);

        repeat (2) step(1'b1, 1'b0, '0, 1'b0);
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1..all: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule